// File: doc/BRIEF.md
# Timer Break and Output-Enable Guard

This block sits between the PWM generator of a timer and its pins. Each channel has a true output and a complementary output. The block holds one 16-bit protection register. The register carries a master output enable, an auto re-enable bit, a break level select, a break enable, two off-state select bits, a two-bit lock level and an eight-bit dead-time value. The two off-state bits and the dead-time value are stored and read back only. A bus write carries two byte enables, so a half-word or a word store can update the high byte, the low byte or both.

While an enabled break input is at its active level, the master enable reads 0 and every output drops to 0 in that same cycle, with no clock edge in between. The master enable comes back only in one of two ways: software writes it, or an update-event pulse arrives while auto re-enable is set and the break is inactive. When the lock level is not zero, software cannot change the auto re-enable bit.

The master enable is controlled by a three-state machine:
- OE_OFF: outputs are disabled.
- OE_RUN: outputs are enabled.
- OE_TRIP: a break has been seen.

Its transitions are:
- ARM: OE_OFF or OE_TRIP to OE_RUN. Taken on a software set, or on an update event with auto re-enable set, and only while the break is inactive.
- DISARM: OE_RUN to OE_OFF. Taken on a software clear.
- TRIP: any state to OE_TRIP. Taken while the break is active.
- RELEASE: OE_TRIP to OE_OFF. Taken when the break goes inactive and no re-arm happens in the same cycle.

Top module: `tmr_brk_guard`

## Requirements
- R1: After reset the register reads 0x0000 and every output is 0.
- R2: Register bit positions:
  - bits 7:0 are the dead-time value;
  - bits 9:8 are the lock level;
  - bit 10 and bit 11 are the off-state selects;
  - bit 12 is the break enable;
  - bit 13 is the break level select;
  - bit 14 is auto re-enable;
  - bit 15 is the master enable.

  Byte enable 0 writes bits 7:0. Byte enable 1 writes bits 15:8.
- R3: The break counts as active only when the break enable is 1 and the break input equals the level select (1 means active high, 0 means active low). In any other case it has no effect.
- R4: While the break is active, the master enable reads 0 and all outputs are 0 in the same cycle, without waiting for a clock edge.
- R5: A software write of 1 to the master enable in a cycle where the break is active is lost. The enable still reads 0 after the break goes away.
- R6: With auto re-enable at 1, an update-event pulse with the break inactive sets the master enable at the next clock edge.
- R7: An update event never sets the master enable while auto re-enable is 0 or while the break is active.
- R8: A write to the high byte changes auto re-enable only when the lock level is 00 before the write. At any other lock level the bit keeps its value.
- R9: While the master enable is 0, every true and complementary output is 0.
- R10: While the master enable is 1, each output follows its PWM input ANDed with that output's own enable bit.
- R11: Once a break ends, the master enable stays 0 until software sets it or an auto re-enable update sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: bit 0 for the low byte, bit 1 for the high byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register readback; bit 15 is the effective master enable |
| brk_in | input | 1 | Raw break input |
| upd_evt | input | 1 | Timer update-event pulse |
| ch_en_p | input | NUM_CH | Enable for each true output |
| ch_en_n | input | NUM_CH | Enable for each complementary output |
| pwm_p | input | NUM_CH | Raw true PWM signals |
| pwm_n | input | NUM_CH | Raw complementary PWM signals |
| out_p | output | NUM_CH | Gated true outputs |
| out_n | output | NUM_CH | Gated complementary outputs |

## Verification
The bench builds the block with NUM_CH = 3 rather than the default of 4. The odd channel count makes the per-channel generate loop give each output its own enable on an unequal width. A bit leaking across channels, or a fixed mask of four, would show up as a mismatch.

With only three channels, random enable and PWM patterns cover every gating combination often. That leaves cycles for the break, update and lock corner cases.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

    localparam int REG_W    = 16;
    localparam int DT_W     = 8;
    localparam int BIT_MOE  = 15;
    localparam int BIT_AOE  = 14;
    localparam int BIT_POL  = 13;
    localparam int BIT_BEN  = 12;
    localparam int BIT_ROS  = 11;
    localparam int BIT_IOS  = 10;
    localparam int LOCK_LO  = 8;
    localparam int LOCK_W   = 2;

    typedef enum logic [1:0] {
        OE_OFF  = 2'd0,
        OE_RUN  = 2'd1,
        OE_TRIP = 2'd2
    } oe_state_e;

    typedef struct packed {
        logic              aoe;
        logic              pol;
        logic              brk_en;
        logic              ros;
        logic              ios;
        logic [LOCK_W-1:0] lock;
        logic [DT_W-1:0]   dt;
    } guard_cfg_t;

endpackage

// File: rtl/tbg_regs.sv
module tbg_regs
    import tbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_be,
    input  logic [REG_W-1:0] wr_data,
    output guard_cfg_t       cfg,
    output logic             sw_set,
    output logic             sw_clr
);

    logic hi_wr;
    logic lo_wr;
    logic unlocked;

    assign hi_wr    = wr_en & wr_be[1];
    assign lo_wr    = wr_en & wr_be[0];
    assign unlocked = (cfg.lock == '0);
    assign sw_set   = hi_wr &  wr_data[BIT_MOE];
    assign sw_clr   = hi_wr & ~wr_data[BIT_MOE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (lo_wr) begin
                cfg.dt <= wr_data[DT_W-1:0];
            end
            if (hi_wr) begin
                cfg.pol    <= wr_data[BIT_POL];
                cfg.brk_en <= wr_data[BIT_BEN];
                cfg.ros    <= wr_data[BIT_ROS];
                cfg.ios    <= wr_data[BIT_IOS];
                cfg.lock   <= wr_data[LOCK_LO +: LOCK_W];
                if (unlocked) begin
                    cfg.aoe <= wr_data[BIT_AOE];
                end
            end
        end
    end

endmodule

// File: rtl/tbg_brk_sense.sv
module tbg_brk_sense (
    input  logic brk_in,
    input  logic pol,
    input  logic brk_en,
    output logic brk_act
);

    // pol = 1 selects active-high, pol = 0 selects active-low
    always_comb begin
        brk_act = brk_en & (brk_in ^ ~pol);
    end

endmodule

// File: rtl/tbg_oe_fsm.sv
module tbg_oe_fsm
    import tbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      brk_act,
    input  logic      sw_set,
    input  logic      sw_clr,
    input  logic      upd_evt,
    input  logic      aoe,
    output logic      moe,
    output oe_state_e state
);

    oe_state_e state_nx;
    logic      arm_req;

    assign arm_req = sw_set | (upd_evt & aoe);

    always_comb begin
        state_nx = state;
        if (brk_act) begin
            state_nx = OE_TRIP;                                  // TRIP
        end else begin
            unique case (state)
                OE_RUN:  state_nx = sw_clr  ? OE_OFF : OE_RUN;   // DISARM
                OE_OFF:  state_nx = arm_req ? OE_RUN : OE_OFF;   // ARM
                OE_TRIP: state_nx = arm_req ? OE_RUN : OE_OFF;   // ARM / RELEASE
                default: state_nx = OE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OE_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // break masks the enable combinationally, before any edge
    always_comb begin
        moe = (state == OE_RUN) & ~brk_act;
    end

endmodule

// File: rtl/tbg_gate.sv
module tbg_gate #(
    parameter int NUM_CH = 4
) (
    input  logic              moe,
    input  logic [NUM_CH-1:0] ch_en_p,
    input  logic [NUM_CH-1:0] ch_en_n,
    input  logic [NUM_CH-1:0] pwm_p,
    input  logic [NUM_CH-1:0] pwm_n,
    output logic [NUM_CH-1:0] out_p,
    output logic [NUM_CH-1:0] out_n
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign out_p[c] = moe & ch_en_p[c] & pwm_p[c];
        assign out_n[c] = moe & ch_en_n[c] & pwm_n[c];
    end

endmodule

// File: rtl/tmr_brk_guard.sv
module tmr_brk_guard
    import tbg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_be,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic              brk_in,
    input  logic              upd_evt,
    input  logic [NUM_CH-1:0] ch_en_p,
    input  logic [NUM_CH-1:0] ch_en_n,
    input  logic [NUM_CH-1:0] pwm_p,
    input  logic [NUM_CH-1:0] pwm_n,
    output logic [NUM_CH-1:0] out_p,
    output logic [NUM_CH-1:0] out_n
);

    guard_cfg_t cfg;
    logic       sw_set;
    logic       sw_clr;
    logic       brk_act;
    logic       moe;
    oe_state_e  state;

    tbg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .cfg     (cfg),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr)
    );

    tbg_brk_sense u_brk (
        .brk_in  (brk_in),
        .pol     (cfg.pol),
        .brk_en  (cfg.brk_en),
        .brk_act (brk_act)
    );

    tbg_oe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_act (brk_act),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .upd_evt (upd_evt),
        .aoe     (cfg.aoe),
        .moe     (moe),
        .state   (state)
    );

    tbg_gate #(.NUM_CH(NUM_CH)) u_gate (
        .moe     (moe),
        .ch_en_p (ch_en_p),
        .ch_en_n (ch_en_n),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n),
        .out_p   (out_p),
        .out_n   (out_n)
    );

    assign rd_data = {moe, cfg.aoe, cfg.pol, cfg.brk_en, cfg.ros, cfg.ios,
                      cfg.lock, cfg.dt};

endmodule

// File: rtl/tbg_guard_chk.sv
module tbg_guard_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_be,
    input logic [15:0]       wr_data,
    input logic [15:0]       rd_data,
    input logic              brk_in,
    input logic              upd_evt,
    input logic [NUM_CH-1:0] ch_en_p,
    input logic [NUM_CH-1:0] ch_en_n,
    input logic [NUM_CH-1:0] pwm_p,
    input logic [NUM_CH-1:0] pwm_n,
    input logic [NUM_CH-1:0] out_p,
    input logic [NUM_CH-1:0] out_n
);

    logic brk_seen;
    logic sw_arm;

    assign brk_seen = rd_data[12] & (brk_in == rd_data[13]);
    assign sw_arm   = wr_en & wr_be[1] & wr_data[15];

    assert_brk_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_seen |-> (!rd_data[15] && out_p == '0 && out_n == '0));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> (out_p == '0 && out_n == '0));

    assert_gate_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_p & ~(pwm_p & ch_en_p)) == '0) && ((out_n & ~(pwm_n & ch_en_n)) == '0));

    assert_aoe_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[1] && rd_data[9:8] != 2'b00) |=> rd_data[14] == $past(rd_data[14]));

    assert_no_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[15] && !sw_arm && (!rd_data[14] || !upd_evt)) |=> !rd_data[15]);

    assert_brk_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_seen && !(upd_evt && rd_data[14])) |=> !rd_data[15] || sw_arm);

endmodule

bind tmr_brk_guard tbg_guard_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tmr_brk_guard_test.sv
`timescale 1ns/1ps
module tmr_brk_guard_test;

    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_be = '0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;
    logic          brk_in = 1'b0;
    logic          upd_evt = 1'b0;
    logic [NC-1:0] ch_en_p = '0, ch_en_n = '0, pwm_p = '0, pwm_n = '0;
    logic [NC-1:0] out_p, out_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    logic       m_run;
    logic [14:0] m_cfg;   // bits 14:0 of the register

    always #4 clk = ~clk;

    tmr_brk_guard #(.NUM_CH(NC)) uut (.*);

    function automatic logic m_brk();
        return m_cfg[12] & (brk_in == m_cfg[13]);
    endfunction

    function automatic logic m_moe();
        return m_run & ~m_brk();
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic hi, lo, brk, run_n;
        logic [14:0] c;
        hi = wr_en & wr_be[1];
        lo = wr_en & wr_be[0];
        brk = m_brk();
        c = m_cfg;
        if (brk)               run_n = 1'b0;
        else if (m_run)        run_n = !(hi && !wr_data[15]);
        else                   run_n = (hi && wr_data[15]) || (upd_evt && m_cfg[14]);
        if (lo) c[7:0] = wr_data[7:0];
        if (hi) begin
            c[13:8] = wr_data[13:8];
            if (m_cfg[9:8] == 2'b00) c[14] = wr_data[14];
        end
        m_run = run_n;
        m_cfg = c;
    endtask

    // inputs are set after a negedge; check, take the edge, return at negedge
    task automatic tick();
        logic [NC-1:0] ep, en;
        #1;
        ep = m_moe() ? (pwm_p & ch_en_p) : '0;
        en = m_moe() ? (pwm_n & ch_en_n) : '0;
        check(m_brk() ? "R4 out" : (m_moe() ? "R10 out" : "R9 out"),
              {8'd0, 1'b0, ep, 1'b0, en}, {8'd0, 1'b0, out_p, 1'b0, out_n});
        check("R2 readback", rd_data, {m_moe(), m_cfg});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 1'b0; wr_be = '0; upd_evt = 1'b0;
    endtask

    task automatic write(input logic [1:0] be, input logic [15:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d; upd_evt = 1'b0;
        tick();
        quiet();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        m_run = 1'b0;
        m_cfg = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset rd", rd_data, 16'h0000);
        check("R1 reset out", {10'd0, out_p, out_n}, 16'h0000);
        rst_n = 1'b1;
        ch_en_p = '1; ch_en_n = '1; pwm_p = 3'b101; pwm_n = 3'b010;
        tick();

        // R2: byte enables write separate halves
        write(2'b01, 16'hFFA5);
        check("R2 low byte only", rd_data, 16'h00A5);
        write(2'b10, 16'h0C33);
        check("R2 high byte only", rd_data, 16'h0CA5);
        write(2'b11, 16'h0000);

        // R3: active high, enabled; set enable then break
        write(2'b10, 16'hB000);              // moe=1, pol=1, ben=1
        brk_in = 1'b0; #1;
        check("R10 enabled", {10'd0, out_p, out_n}, {10'd0, 3'b101, 3'b010});
        brk_in = 1'b1; #1;                   // R4: same cycle, no edge
        check("R4 same-cycle clear", {rd_data[15], 9'd0, out_p, out_n}, 16'h0000);
        tick();
        brk_in = 1'b0; tick();
        check("R11 stays off after break", {15'd0, rd_data[15]}, 16'h0000);

        // R3: polarity low means brk_in=1 inactive
        write(2'b10, 16'h9000);              // moe=1, pol=0, ben=1
        brk_in = 1'b1; tick();
        check("R3 inactive level ignored", {15'd0, rd_data[15]}, 16'h0001);
        brk_in = 1'b0; #1;
        check("R3 active-low trips", {15'd0, rd_data[15]}, 16'h0000);
        tick();
        brk_in = 1'b1;
        write(2'b10, 16'h8000);              // ben=0, moe=1
        brk_in = 1'b0; tick();
        check("R3 disabled break ignored", {15'd0, rd_data[15]}, 16'h0001);

        // R5: write 1 during break is lost
        write(2'b10, 16'h3000);              // moe=0, pol=1, ben=1
        brk_in = 1'b1;
        write(2'b10, 16'hB000);
        brk_in = 1'b0; #1;
        check("R5 break beats write", {15'd0, rd_data[15]}, 16'h0001 & {15'd0, m_moe()});
        check("R5 enable low", {15'd0, rd_data[15]}, 16'h0000);
        tick();

        // R6 / R7: auto re-enable
        write(2'b10, 16'h7000);              // aoe=1, pol=1, ben=1, moe=0
        brk_in = 1'b1; upd_evt = 1'b1; tick();
        brk_in = 1'b0; upd_evt = 1'b0; #1;
        check("R7 no re-arm under break", {15'd0, rd_data[15]}, 16'h0000);
        upd_evt = 1'b1; tick(); upd_evt = 1'b0; #1;
        check("R6 re-arm on update", {15'd0, rd_data[15]}, 16'h0001);
        tick();
        write(2'b10, 16'h3000);              // aoe=0, moe=0
        upd_evt = 1'b1; tick(); upd_evt = 1'b0; #1;
        check("R7 no re-arm when aoe=0", {15'd0, rd_data[15]}, 16'h0000);
        tick();

        // R8: lock
        write(2'b10, 16'h4100);              // aoe=1, lock=01 (aoe writable now)
        write(2'b10, 16'h0100);              // try aoe=0 at lock 01
        check("R8 aoe held at lock 01", {15'd0, rd_data[14]}, 16'h0001);
        write(2'b10, 16'h0300);
        write(2'b10, 16'h0000);              // lock 11 -> aoe kept, lock cleared
        check("R8 aoe held at lock 11", {15'd0, rd_data[14]}, 16'h0001);
        write(2'b10, 16'h0000);              // lock 00 now: aoe clears
        check("R8 aoe writable at lock 00", {15'd0, rd_data[14]}, 16'h0000);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            wr_en   = ($urandom % 6) == 0;
            wr_be   = $urandom;
            wr_data = $urandom;
            if (($urandom % 3) != 0) wr_data[9:8] = 2'b00;
            brk_in  = ($urandom % 5) == 0;
            upd_evt = ($urandom % 4) == 0;
            ch_en_p = $urandom; ch_en_n = $urandom;
            pwm_p   = $urandom; pwm_n   = $urandom;
            tick();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule